// File: doc/BRIEF.md
# Command Slot Receiver and Decoder

This block sits behind the line demodulator of a command bus terminal. It takes a stream of demodulated bits, one bit per strobe, plus a one-clock pulse that marks a detected sync pattern. After the sync pulse it shifts in the body of one command slot, MSB first. The body holds a broadcast field, a terminal address, a destination address, a data word and a trailing parity bit. When the last bit arrives, the block splits the body into its fields.

At the end of each complete slot the block raises `slot_end` for one clock. In the same cycle it updates three flags and the decoded fields: broadcast, address match and parity error. These flags and fields then hold until the next complete slot. `cmd_valid` is a one-clock pulse in the same cycle. It is raised only for a command that this terminal should act on.

A static mode input selects the split between the broadcast field and the address field. The other slot fields do not change with the mode.

Top module: `cmd_slot_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `slot_end`, `cmd_valid`, every flag and every field output read 0.
- R2: With `wide_mode`=0, a slot body is 29 bits received MSB first after the sync pulse. The order is 3 broadcast bits, then 5 address bits, then 4 destination bits, then 16 data bits (MSB first), then the parity bit. `cmd_addr` returns the address zero-extended.
- R3: With `wide_mode`=1, a slot body is 31 bits received MSB first after the sync pulse. The order is 4 broadcast bits, then 6 address bits, then the same destination, data and parity fields.
- R4: Parity is odd. `cmd_perr` is 1 exactly when the count of ones over the broadcast, address, destination, data and parity bits of the slot is even.
- R5: `cmd_match` is 1 when the received address equals `local_addr`. In narrow mode only `local_addr[4:0]` takes part, and `local_addr[5]` has no effect.
- R6: `cmd_bcast` is 1 when every bit of the broadcast field is 1. A broadcast command counts as accepted whatever its address.
- R7: `cmd_valid` is high for exactly one clock. That clock is the second rising edge after the edge that samples the parity bit's strobe, together with `slot_end`. It is high only when `cmd_perr` is 0 and either `cmd_match` or `cmd_bcast` is 1.
- R8: A sync pulse during a slot discards the partial slot and restarts reception. The discarded slot produces no `slot_end` or `cmd_valid`. A sync pulse on the same edge as a bit strobe takes priority over the strobe.
- R9: Bit strobes that arrive before any sync pulse, or after a slot has completed, change no output.
- R10: The flags and field outputs change only in a cycle where `slot_end` is 1. They hold their values between slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | Static split select: 0 = 3 broadcast + 5 address bits, 1 = 4 + 6 |
| local_addr | input | 6 | Strapped terminal address |
| sync_pulse | input | 1 | One-clock pulse when the sync pattern is detected |
| bit_stb | input | 1 | Strobe marking a valid demodulated bit |
| bit_val | input | 1 | Demodulated bit value, sampled with `bit_stb` |
| slot_end | output | 1 | One-clock pulse when a complete slot has been decoded |
| cmd_valid | output | 1 | One-clock pulse for an accepted command |
| cmd_bcast | output | 1 | Broadcast field was all ones |
| cmd_match | output | 1 | Address equalled `local_addr` |
| cmd_perr | output | 1 | Odd parity check failed |
| cmd_addr | output | 6 | Received terminal address |
| cmd_dest | output | 4 | Received destination address |
| cmd_data | output | 16 | Received data word |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 4-bit destination field, and a 3/5 narrow split that widens to 4/6. With these sizes a full sweep is small. It sends every broadcast pattern against every address in both modes, and corrupts parity on a regular arithmetic subset of those slots. The strapped address has its top bit set, so the narrow-mode sweep also shows that this bit has no effect. Separate sequences cover an aborted slot, and strobes sent without a sync pulse.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  typedef struct packed {
    logic bcast;
    logic match;
    logic perr;
  } cmd_flags_t;
endpackage

// File: rtl/cmd_rx_shift.sv
module cmd_rx_shift #(
  parameter int BODY_MAX = 31,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_pulse,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic [CNT_W-1:0]    body_len,
  output logic [BODY_MAX-1:0] sh,
  output logic                done
);
  logic             active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sync_pulse) begin
        // sync wins over any strobe on the same edge (R8)
        active <= 1'b1;
        cnt    <= '0;
        sh     <= '0;
      end else if (active && bit_stb) begin
        sh <= {sh[BODY_MAX-2:0], bit_val};
        if (cnt == body_len - 1'b1) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_rx_decode.sv
module cmd_rx_decode
  import cmd_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEST_W = 4,
  parameter int BC_N   = 3,
  parameter int TA_N   = 5
) (
  input  logic [BC_N+TA_N+DEST_W+DATA_W+2:0] sh,
  input  logic                               wide,
  input  logic [TA_N:0]                      local_addr,
  output logic [TA_N:0]                      addr,
  output logic [DEST_W-1:0]                  dest,
  output logic [DATA_W-1:0]                  data,
  output cmd_flags_t                         flags
);
  localparam int AB = DATA_W + DEST_W + 1;

  logic [TA_N-1:0] addr_n;
  logic [TA_N:0]   addr_w;
  logic [BC_N-1:0] bc_n;
  logic [BC_N:0]   bc_w;

  assign data   = sh[DATA_W:1];
  assign dest   = sh[DATA_W+DEST_W:DATA_W+1];
  assign addr_n = sh[AB +: TA_N];
  assign addr_w = sh[AB +: TA_N+1];
  assign bc_n   = sh[AB+TA_N +: BC_N];
  assign bc_w   = sh[AB+TA_N+1 +: BC_N+1];

  always_comb begin
    if (wide) begin
      addr        = addr_w;
      flags.bcast = &bc_w;
      flags.match = (addr_w == local_addr);
    end else begin
      addr        = {1'b0, addr_n};
      flags.bcast = &bc_n;
      flags.match = (addr_n == local_addr[TA_N-1:0]);
    end
    // bits above the body are cleared at sync, so the full-width xor is the body xor
    flags.perr = ~(^sh);
  end
endmodule

// File: rtl/cmd_slot_rx.sv
module cmd_slot_rx
  import cmd_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEST_W = 4,
  parameter int BC_N   = 3,
  parameter int TA_N   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic [TA_N:0]     local_addr,
  input  logic              sync_pulse,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              slot_end,
  output logic              cmd_valid,
  output logic              cmd_bcast,
  output logic              cmd_match,
  output logic              cmd_perr,
  output logic [TA_N:0]     cmd_addr,
  output logic [DEST_W-1:0] cmd_dest,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int BODY_MAX = BC_N + TA_N + DEST_W + DATA_W + 3;
  localparam int CNT_W    = $clog2(BODY_MAX + 1);

  logic [BODY_MAX-1:0] sh;
  logic                done;
  logic [CNT_W-1:0]    body_len;
  logic [TA_N:0]       d_addr;
  logic [DEST_W-1:0]   d_dest;
  logic [DATA_W-1:0]   d_data;
  cmd_flags_t          d_flags;

  assign body_len = wide_mode ? CNT_W'(BODY_MAX) : CNT_W'(BODY_MAX - 2);

  cmd_rx_shift #(.BODY_MAX(BODY_MAX), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .sync_pulse(sync_pulse), .bit_stb(bit_stb),
    .bit_val(bit_val), .body_len(body_len), .sh(sh), .done(done)
  );

  cmd_rx_decode #(.DATA_W(DATA_W), .DEST_W(DEST_W), .BC_N(BC_N), .TA_N(TA_N)) u_dec (
    .sh(sh), .wide(wide_mode), .local_addr(local_addr),
    .addr(d_addr), .dest(d_dest), .data(d_data), .flags(d_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_end  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_bcast <= 1'b0;
      cmd_match <= 1'b0;
      cmd_perr  <= 1'b0;
      cmd_addr  <= '0;
      cmd_dest  <= '0;
      cmd_data  <= '0;
    end else begin
      slot_end  <= done;
      cmd_valid <= done && !d_flags.perr && (d_flags.match || d_flags.bcast);
      if (done) begin
        cmd_bcast <= d_flags.bcast;
        cmd_match <= d_flags.match;
        cmd_perr  <= d_flags.perr;
        cmd_addr  <= d_addr;
        cmd_dest  <= d_dest;
        cmd_data  <= d_data;
      end
    end
  end
endmodule

// File: rtl/cmd_slot_rx_chk.sv
module cmd_slot_rx_chk (
  input logic clk,
  input logic rst,
  input logic sync_pulse,
  input logic slot_end,
  input logic cmd_valid,
  input logic cmd_bcast,
  input logic cmd_match,
  input logic cmd_perr
);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_valid_gate_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (slot_end && !cmd_perr && (cmd_match || cmd_bcast)));

  assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_end && cmd_bcast && !cmd_perr) |-> cmd_valid);

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> ##1 !slot_end);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !slot_end |-> ($stable(cmd_bcast) && $stable(cmd_match) && $stable(cmd_perr)));
endmodule

bind cmd_slot_rx cmd_slot_rx_chk u_chk (
  .clk(clk), .rst(rst), .sync_pulse(sync_pulse), .slot_end(slot_end),
  .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .cmd_match(cmd_match),
  .cmd_perr(cmd_perr)
);

// File: tb/cmd_slot_rx_tb.sv
module cmd_slot_rx_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wide_mode = 0;
  logic [5:0]  local_addr = 6'h33;
  logic        sync_pulse = 0, bit_stb = 0, bit_val = 0;
  logic        slot_end, cmd_valid, cmd_bcast, cmd_match, cmd_perr;
  logic [5:0]  cmd_addr;
  logic [3:0]  cmd_dest;
  logic [15:0] cmd_data;

  int n_run = 0, n_fail = 0, n_end = 0;

  always #5 clk = ~clk;

  cmd_slot_rx u_dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .local_addr(local_addr),
    .sync_pulse(sync_pulse), .bit_stb(bit_stb), .bit_val(bit_val),
    .slot_end(slot_end), .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast),
    .cmd_match(cmd_match), .cmd_perr(cmd_perr), .cmd_addr(cmd_addr),
    .cmd_dest(cmd_dest), .cmd_data(cmd_data)
  );

  always @(negedge clk) if (!rst && slot_end) n_end++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_sync();
    @(negedge clk) sync_pulse = 1;
    @(negedge clk) sync_pulse = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) begin bit_stb = 1; bit_val = b; end
    @(negedge clk) bit_stb = 0;
  endtask

  task automatic send_body(input bit wide, input int bc, input int addr,
                           input int dest, input int data, input bit bad);
    logic [31:0] v;
    int n;
    logic p;
    if (wide) begin
      n = 31;
      v = {1'b0, 4'(bc), 6'(addr), 4'(dest), 16'(data), 1'b0};
    end else begin
      n = 29;
      v = {3'b0, 3'(bc), 5'(addr), 4'(dest), 16'(data), 1'b0};
    end
    p = ~(^v) ^ bad;
    v[0] = p;
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic run_slot(input bit wide, input int bc, input int addr, input bit bad);
    int dest, data;
    bit e_bc, e_m, e_v;
    dest = (addr ^ bc) & 15;
    data = (bc * 37 + addr * 911 + 5) & 16'hffff;
    do_sync();
    send_body(wide, bc, addr, dest, data, bad);
    @(negedge clk);
    e_bc = wide ? (bc == 15) : (bc == 7);
    e_m  = wide ? (addr == int'(local_addr)) : (addr == int'(local_addr[4:0]));
    e_v  = !bad && (e_bc || e_m);
    check(slot_end == 1, "R7 slot_end", slot_end, 1);
    check(cmd_valid == e_v, "R7 cmd_valid", cmd_valid, e_v);
    check(cmd_bcast == e_bc, "R6 cmd_bcast", cmd_bcast, e_bc);
    check(cmd_match == e_m, "R5 cmd_match", cmd_match, e_m);
    check(cmd_perr == bad, "R4 cmd_perr", cmd_perr, bad);
    check(cmd_data == 16'(data), wide ? "R3 data" : "R2 data", cmd_data, data);
    check(cmd_dest == 4'(dest), wide ? "R3 dest" : "R2 dest", cmd_dest, dest);
    check(cmd_addr == 6'(addr), wide ? "R3 addr" : "R2 addr", cmd_addr, addr);
    @(negedge clk);
    check(cmd_valid == 0 && slot_end == 0, "R7 single pulse", cmd_valid, 0);
    check(cmd_data == 16'(data), "R10 hold", cmd_data, data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n0;
    logic [15:0] d0;
    repeat (3) @(negedge clk);
    check({slot_end, cmd_valid, cmd_bcast, cmd_match, cmd_perr, cmd_addr, cmd_dest, cmd_data} == 0,
          "R1 reset outputs", cmd_data, 0);
    rst = 0;
    @(negedge clk);
    check({slot_end, cmd_valid, cmd_bcast, cmd_match, cmd_perr, cmd_addr, cmd_dest, cmd_data} == 0,
          "R1 after reset", cmd_data, 0);

    // R9: strobes with no sync do nothing
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    repeat (2) @(negedge clk);
    check(n_end == 0, "R9 no slot without sync", n_end, 0);
    check(cmd_data == 0 && cmd_bcast == 0, "R9 outputs untouched", cmd_data, 0);

    // R2 narrow sweep; local_addr[5] set, low bits 0x13
    wide_mode = 0;
    for (int bc = 0; bc < 8; bc++)
      for (int a = 0; a < 32; a++)
        run_slot(1'b0, bc, a, ((a + bc) % 5) == 0);

    // R3 wide sweep
    wide_mode = 1;
    local_addr = 6'h2a;
    for (int bc = 0; bc < 16; bc++)
      for (int a = 0; a < 64; a++)
        run_slot(1'b1, bc, a, ((a + bc) % 7) == 0);

    // R8 abort mid-slot then full slot
    n0 = n_end;
    do_sync();
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    run_slot(1'b1, 0, 42, 1'b0);
    check(n_end - n0 == 1, "R8 aborted slot silent", n_end - n0, 1);

    // R8 sync on same edge as a strobe wins
    n0 = n_end;
    do_sync();
    for (int i = 0; i < 30; i++) send_bit(1'b0);
    @(negedge clk) begin bit_stb = 1; bit_val = 1; sync_pulse = 1; end
    @(negedge clk) begin bit_stb = 0; sync_pulse = 0; end
    repeat (2) @(negedge clk);
    check(n_end == n0, "R8 sync beats strobe", n_end - n0, 0);
    run_slot(1'b1, 15, 3, 1'b0);

    // R9 strobes after completion ignored
    n0 = n_end;
    d0 = cmd_data;
    for (int i = 0; i < 35; i++) send_bit(1'b1);
    repeat (2) @(negedge clk);
    check(n_end == n0, "R9 post-slot strobes", n_end - n0, 0);
    check(cmd_data == d0, "R9 data held", cmd_data, d0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule